// File: doc/BRIEF.md
# Vector Upper-Half Dirty Tracker and Width Promoter

This block follows, for each of sixteen vector registers, whether the bits above the low 128 hold live data. It keeps two flags for each register: one for bits 128 to 255 and one for bits 256 to 511. From these flags it works out the width at which every incoming vector-register instruction must be treated by the power-state logic.

While any register carries live upper bits, every instruction that touches vector registers is promoted to the widest dirty width. This covers narrow SIMD operations and scalar floating-point operations alike. The instruction's light/heavy class is passed along unchanged at the promoted width, so a narrow heavy operation is reported as heavy at full width. A zero-upper command wipes every flag.

The result appears combinationally in the same cycle as the instruction. It is computed from the flags as they stood before that instruction's own destination write, and flag changes become visible from the following cycle.

Top module: `vwiden_tracker`

## Requirements
- R1: Width codes are 2'b00 scalar, 2'b01 128-bit, 2'b10 256-bit and 2'b11 512-bit. After reset no flag is set, and a valid vector instruction reports its own native width.
- R2: While the 128–255 flag of any register is set, a valid vector instruction reports a width of at least 2'b10. The reported width is the larger of the native width and the promoted width.
- R3: While the 256–511 flag of any register is set, a valid vector instruction reports 2'b11.
- R4: A scalar (2'b00) vector-register instruction is promoted exactly like a 128-bit one.
- R5: For a valid vector instruction, `out_heavy` equals `in_heavy` whatever promotion occurs.
- R6: A destination write (`in_valid`, `in_vec` and `in_dst_we` all high) changes the flags of register `in_dst` only:
  - native 2'b10 sets its 128–255 flag and clears its 256–511 flag;
  - native 2'b11 sets both flags;
  - native 2'b01 or 2'b00 clears both flags.
- R7: While `in_zero_upper` is high, every flag is cleared at the next edge. It overrides a destination write in the same cycle.
- R8: The reported width uses the flags from before the current instruction's write. The write takes effect from the next cycle.
- R9: An instruction with `in_vec` low reports scalar and `out_heavy` 0, and it changes no flag even with `in_dst_we` high.
- R10: With `in_valid` low the outputs are scalar and 0, and no destination write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Instruction present this cycle |
| in_vec | input | 1 | Instruction uses vector registers |
| in_width | input | 2 | Native operation width code |
| in_dst | input | IDX_W | Destination register index |
| in_dst_we | input | 1 | Instruction writes its destination register |
| in_heavy | input | 1 | Light (0) / heavy (1) class |
| in_zero_upper | input | 1 | Clear every upper-half flag |
| out_width | output | 2 | Effective width code |
| out_heavy | output | 1 | Class at the effective width |

## Verification
The assertions take for granted that `rst_n` is low at time zero and that every input is settled and free of unknowns at each clock edge. They also assume `in_dst` is always below the register count; with the default of sixteen registers every index value is legal, so this assumption cannot be broken.

The stimulus changes inputs only on the falling edge and draws the destination index across the full 4-bit range. This keeps it inside those assumptions. Against that, it sweeps every combination of:
- native width;
- class;
- vector flag;
- a single dirty register placed at each index.

A long pseudo-random sequence then mixes writes, zero-upper commands and idle cycles.

// File: rtl/vwiden_pkg.sv
package vwiden_pkg;
  typedef enum logic [1:0] {
    VW_SCALAR = 2'b00,
    VW_128    = 2'b01,
    VW_256    = 2'b10,
    VW_512    = 2'b11
  } vw_width_e;
endpackage

// File: rtl/vwiden_flag_bank.sv
module vwiden_flag_bank
  import vwiden_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [1:0]          wr_width,
  input  logic                zero_all,
  output logic [NUM_REGS-1:0] lo_q,
  output logic [NUM_REGS-1:0] hi_q
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    logic lo_d, hi_d, flag_en;

    assign hit     = wr_en && (wr_idx == IDX_W'(i));
    assign flag_en = zero_all || hit;

    always_comb begin
      lo_d = lo_q[i];
      hi_d = hi_q[i];
      if (zero_all) begin
        lo_d = 1'b0;
        hi_d = 1'b0;
      end else if (hit) begin
        unique case (vw_width_e'(wr_width))
          VW_512:  begin lo_d = 1'b1; hi_d = 1'b1; end
          VW_256:  begin lo_d = 1'b1; hi_d = 1'b0; end
          default: begin lo_d = 1'b0; hi_d = 1'b0; end
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[i] <= 1'b0;
        hi_q[i] <= 1'b0;
      end else if (flag_en) begin
        lo_q[i] <= lo_d;
        hi_q[i] <= hi_d;
      end
    end
  end

  // R7: a zero-upper command leaves every flag clear
  p_zero_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_all |=> (lo_q == '0) && (hi_q == '0));

  // R6: a 512-bit write sets both flags of its destination
  p_w512_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !zero_all && wr_width == 2'b11) |=>
      (lo_q[$past(wr_idx)] && hi_q[$past(wr_idx)]));

  // R6: a 256-bit write leaves only the low upper flag set
  p_w256_lo_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !zero_all && wr_width == 2'b10) |=>
      (lo_q[$past(wr_idx)] && !hi_q[$past(wr_idx)]));

  // R6: the update rules never leave a high flag without its low flag
  p_hi_implies_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q & ~lo_q) == '0);

endmodule

// File: rtl/vwiden_resolve.sv
module vwiden_resolve
  import vwiden_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_vec,
  input  logic [1:0]          in_width,
  input  logic                in_heavy,
  input  logic [NUM_REGS-1:0] lo_q,
  input  logic [NUM_REGS-1:0] hi_q,
  output logic [1:0]          out_width,
  output logic                out_heavy
);

  logic      any_lo, any_hi, active;
  vw_width_e floor_w;

  assign any_lo = |lo_q;
  assign any_hi = |hi_q;
  assign active = in_valid && in_vec;

  always_comb begin
    if (any_hi)      floor_w = VW_512;
    else if (any_lo) floor_w = VW_256;
    else             floor_w = VW_SCALAR;
  end

  always_comb begin
    out_width = VW_SCALAR;
    out_heavy = 1'b0;
    if (active) begin
      out_width = (in_width > floor_w) ? in_width : floor_w;
      out_heavy = in_heavy;
    end
  end

  // R2: a dirty 128-255 half anywhere forces at least 256
  p_lo_min256_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && any_lo) |-> (out_width >= 2'b10));

  // R3: a dirty 256-511 half anywhere forces 512
  p_hi_force512_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && any_hi) |-> (out_width == 2'b11));

  // R5: class passes through unchanged
  p_heavy_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (out_heavy == in_heavy));

  // R9, R10: idle or non-vector slots report scalar, light
  p_inactive_scalar_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (out_width == 2'b00 && !out_heavy));

  // R1: the reported width never falls below the native width
  p_never_narrower_r1: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (out_width >= in_width));

endmodule

// File: rtl/vwiden_tracker.sv
module vwiden_tracker #(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_vec,
  input  logic [1:0]       in_width,
  input  logic [IDX_W-1:0] in_dst,
  input  logic             in_dst_we,
  input  logic             in_heavy,
  input  logic             in_zero_upper,
  output logic [1:0]       out_width,
  output logic             out_heavy
);

  logic [NUM_REGS-1:0] lo_q, hi_q;
  logic                wr_en;

  assign wr_en = in_valid && in_vec && in_dst_we;

  vwiden_flag_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (in_dst),
    .wr_width (in_width),
    .zero_all (in_zero_upper),
    .lo_q     (lo_q),
    .hi_q     (hi_q)
  );

  vwiden_resolve #(.NUM_REGS(NUM_REGS)) i_resolve (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_vec    (in_vec),
    .in_width  (in_width),
    .in_heavy  (in_heavy),
    .lo_q      (lo_q),
    .hi_q      (hi_q),
    .out_width (out_width),
    .out_heavy (out_heavy)
  );

  // R8: a write is not visible in its own cycle; flags hold when nothing acts
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !in_zero_upper) |=> ($stable(lo_q) && $stable(hi_q)));

endmodule

// File: tb/test_vwiden_tracker.sv
module test_vwiden_tracker;
  localparam int NR = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_vec, in_dst_we, in_heavy, in_zero_upper;
  logic [1:0] in_width;
  logic [3:0] in_dst;
  logic [1:0] out_width;
  logic       out_heavy;

  int n_checks = 0;
  int n_errors = 0;
  bit lo_m [NR];
  bit hi_m [NR];
  bit done = 1'b0;

  always #5 clk = ~clk;

  vwiden_tracker #(.NUM_REGS(NR)) i_vwiden_tracker (
    .clk, .rst_n, .in_valid, .in_vec, .in_width, .in_dst, .in_dst_we,
    .in_heavy, .in_zero_upper, .out_width, .out_heavy
  );

  function automatic void check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  // One cycle: drive at negedge, check combinational outputs, then update model at posedge.
  task automatic step(bit v, bit vec, int w, int dst, bit we, bit h, bit zu);
    int fl, ew;
    string tag;
    @(negedge clk);
    in_valid = v; in_vec = vec; in_width = 2'(w); in_dst = 4'(dst);
    in_dst_we = we; in_heavy = h; in_zero_upper = zu;
    #1;
    fl = 0;
    for (int i = 0; i < NR; i++) begin
      if (hi_m[i]) fl = 3;
      else if (lo_m[i] && fl < 2) fl = 2;
    end
    if (!v)        begin ew = 0; tag = "R10"; end
    else if (!vec) begin ew = 0; tag = "R9"; end
    else begin
      ew = (w > fl) ? w : fl;
      if (fl == 3)      tag = "R3";
      else if (fl == 2) tag = (w == 0) ? "R4" : "R2";
      else              tag = "R1";
    end
    check({tag, " width"}, out_width, ew);
    check("R5 heavy", out_heavy, (v && vec && h) ? 1 : 0);
    @(posedge clk);
    if (zu) begin
      for (int i = 0; i < NR; i++) begin lo_m[i] = 0; hi_m[i] = 0; end
    end else if (v && vec && we) begin
      lo_m[dst] = (w >= 2);
      hi_m[dst] = (w == 3);
    end
  endtask

  initial begin
    int guard = 0;
    while (!done && guard < 150000) begin @(posedge clk); guard++; end
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=%0d expected=done", guard);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin lo_m[i] = 0; hi_m[i] = 0; end
    rst_n = 1'b0;
    in_valid = 0; in_vec = 0; in_width = 0; in_dst = 0;
    in_dst_we = 0; in_heavy = 0; in_zero_upper = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, every native width unchanged
    for (int w = 0; w < 4; w++) step(1, 1, w, 0, 0, w[0], 0);

    // Sweep: dirty level x dirty register x native width x class x vec
    for (int lvl = 2; lvl < 4; lvl++) begin
      for (int r = 0; r < NR; r++) begin
        step(1, 1, lvl, r, 1, 0, 0);
        for (int w = 0; w < 4; w++)
          for (int h = 0; h < 2; h++)
            for (int vc = 0; vc < 2; vc++)
              step(1, vc[0], w, (r + 1) % NR, 0, h[0], 0);
        step(1, 1, 1, r, 1, 0, 0);  // R6: narrow write cleans it
        step(1, 1, 0, 0, 0, 1, 0);  // scalar now unpromoted
      end
    end

    // R8: write seen only from next cycle
    step(1, 1, 1, 5, 1, 0, 0);
    step(1, 1, 3, 5, 1, 1, 0);  // reports 512 from own width, flags still clean
    @(negedge clk);
    in_valid = 1; in_vec = 1; in_width = 2'b01; in_dst = 4'd9; in_dst_we = 0;
    in_heavy = 1; in_zero_upper = 0; #1;
    check("R8 next cycle", out_width, 3);
    n_checks++; if (!out_heavy) begin n_errors++; $display("FAIL R5 promoted heavy actual=0 expected=1"); end

    // R6: 256 write clears the 256-511 flag of the same register
    step(1, 1, 2, 5, 1, 0, 0);
    step(1, 1, 1, 2, 0, 0, 0);
    @(negedge clk); in_width = 2'b01; in_dst_we = 0; #1;
    check("R6 256 clears high", out_width, 2);

    // R7: zero-upper wins over a same-cycle 512 write
    step(1, 1, 3, 7, 1, 0, 1);
    @(negedge clk); in_width = 2'b00; in_dst_we = 0; in_zero_upper = 0; #1;
    check("R7 zero wins", out_width, 0);

    // R9 / R10: writes ignored when not vector or not valid
    step(1, 0, 3, 4, 1, 1, 0);
    step(0, 1, 3, 4, 1, 1, 0);
    @(negedge clk); in_valid = 1; in_vec = 1; in_width = 2'b01; in_dst_we = 0; #1;
    check("R9 R10 no write", out_width, 1);

    // Pseudo-random mix
    for (int k = 0; k < 4000; k++) begin
      int rnd;
      rnd = $urandom;
      step(rnd[0] | rnd[1], rnd[2] | rnd[3], rnd[5:4], rnd[9:6], rnd[10],
           rnd[11], (rnd[16:12] == 0));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule